// File: doc/BRIEF.md
# DDR Read Capture with Automatic Resync Polarity

This block takes the read data of one strobe group of a double-data-rate memory and hands it to the system clock domain. The strobe arrives already shifted by a quarter period, so every strobe edge falls in the middle of a stable data window. Three strobe-clocked registers capture the word on the rising edge and the word on the falling edge. They then line both words up behind the same falling strobe edge. A single resampling stage moves the aligned pair into the system domain. An output register presents the pair as one beat with a valid flag.

The resampling edge is not fixed at design time. When the read preamble detector rises, the block records the level of the system clock at that moment. A low level selects the rising system edge for resampling. A high level selects the falling edge, that is, the inverted clock. The choice is frozen until the burst has been delivered. The strobe-domain registers use a synchronous reset, so the strobe must toggle while reset is held.

Top module: `ddr_rd_capture`

## Requirements
- R1: `rise_word` of each delivered beat equals the value of `dq` at the rising `dqs` edge of that beat.
- R2: `fall_word` of each delivered beat equals the value of `dq` at the falling `dqs` edge of the same beat, and it appears in the same cycle as that beat's rising word.
- R3: Beats are delivered in the order the strobe produced them, one beat per system clock cycle, with no idle cycle inside a burst.
- R4: `clk_pol` takes the level of `sys_clk` at the rising edge of `prmb_det` (0 = clock was low, 1 = clock was high).
- R5: With `clk_pol` = 0, a beat is resampled on the first rising `sys_clk` edge after the next rising `dqs` edge. It appears on the outputs one clock later. With `clk_pol` = 1, it is resampled on the first falling `sys_clk` edge after the next rising `dqs` edge. It appears on the outputs at the following rising edge.
- R6: While a burst is still being delivered, a new rising edge of `prmb_det` changes neither `clk_pol` nor the number of beats delivered.
- R7: `word_valid` is high for exactly BURST_LEN consecutive cycles per burst.
- R8: Strobe activity without a preceding rising edge of `prmb_det` produces no `word_valid`.
- R9: While `rst_n` is low (with `dqs` toggling), `word_valid`, `clk_pol`, `rise_word` and `fall_word` are cleared to 0 at each rising `sys_clk` edge.
- R10: After a burst completes, the next rising edge of `prmb_det` re-evaluates `clk_pol`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock, same frequency as the strobe |
| rst_n | input | 1 | Synchronous active-low reset |
| dqs | input | 1 | Read strobe, already delayed a quarter period |
| dq | input | DATA_W | Read data lines of the strobe group |
| prmb_det | input | 1 | Read preamble detected; rises once per burst |
| rise_word | output | DATA_W | Word captured on the rising strobe edge |
| fall_word | output | DATA_W | Word captured on the falling strobe edge |
| word_valid | output | 1 | A beat is presented this cycle |
| clk_pol | output | 1 | Selected resync edge: 0 rising, 1 falling |

## Verification
For each burst, the bench places the preamble edge and the strobe at a known offset from the system clock. From that offset it computes both the polarity due and the cycle in which the first beat must appear. A beat is resampled on the first selected system edge after the next rising strobe edge. It then appears at the next rising system edge: one full cycle later for polarity 0, half a cycle later for polarity 1. All outputs are sampled on the falling system edge, where none of them changes. The first valid beat must be seen exactly at the computed time. The following beats must arrive in the next BURST_LEN-1 cycles, back to back.

// File: rtl/ddr_rd_pkg.sv
`timescale 1ns/1ps
// Shared types for the DDR read capture block.
package ddr_rd_pkg;
    // Which system clock edge the resync stage samples on.
    typedef enum logic {
        RS_RISE = 1'b0,
        RS_FALL = 1'b1
    } rs_pol_e;
endpackage

// File: rtl/ddr_dqs_capture.sv
`timescale 1ns/1ps
// Strobe-domain capture: per data lane, a rise register, a fall register and
// a realign register that moves the rise data behind the falling strobe edge.
// A toggle flips on every falling strobe edge to mark a completed beat.
// Assumes dqs is centred on the dq eye; reset is sampled on strobe edges only.
module ddr_dqs_capture #(
    parameter int DATA_W = 8
) (
    input  logic              dqs,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] dq,
    output logic [DATA_W-1:0] rise_al,
    output logic [DATA_W-1:0] fall_al,
    output logic              beat_tog
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        logic rise_bit;
        logic fall_bit;
        logic realn_bit;

        // Capture the lane on the rising strobe edge.
        always_ff @(posedge dqs) begin
            if (!rst_n) rise_bit <= 1'b0;
            else        rise_bit <= dq[i];
        end

        // Capture the lane on the falling strobe edge and realign the rise bit.
        always_ff @(negedge dqs) begin
            if (!rst_n) begin
                fall_bit  <= 1'b0;
                realn_bit <= 1'b0;
            end else begin
                fall_bit  <= dq[i];
                realn_bit <= rise_bit;
            end
        end

        assign rise_al[i] = realn_bit;
        assign fall_al[i] = fall_bit;
    end

    // Flip once per completed beat so the system side can spot new data.
    always_ff @(negedge dqs) begin
        if (!rst_n) beat_tog <= 1'b0;
        else        beat_tog <= ~beat_tog;
    end
endmodule

// File: rtl/ddr_pol_detect.sv
`timescale 1ns/1ps
// Polarity detection: records the system clock level at the rising edge of
// the preamble-detect input, and loads it as the resync polarity when the
// system side sees a new preamble while no burst is in flight.
// Assumes prmb_det stays high for at least one system clock period.
module ddr_pol_detect
    import ddr_rd_pkg::*;
(
    input  logic    sys_clk,
    input  logic    rst_n,
    input  logic    prmb_det,
    input  logic    busy,
    output rs_pol_e pol,
    output logic    start
);
    logic lvl_at_edge;
    logic prmb_s1;
    logic prmb_s2;

    // Sample the system clock level at the preamble edge.
    always_ff @(posedge prmb_det) begin
        lvl_at_edge <= sys_clk;
    end

    // Bring the preamble flag into the system domain.
    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            prmb_s1 <= 1'b0;
            prmb_s2 <= 1'b0;
        end else begin
            prmb_s1 <= prmb_det;
            prmb_s2 <= prmb_s1;
        end
    end

    assign start = prmb_s1 & ~prmb_s2 & ~busy;

    // Hold the polarity; reload it only at the start of a new burst.
    always_ff @(posedge sys_clk) begin
        if (!rst_n)     pol <= RS_RISE;
        else if (start) pol <= rs_pol_e'(lvl_at_edge);
    end
endmodule

// File: rtl/ddr_rd_resync.sv
`timescale 1ns/1ps
// Resync and delivery: samples the realigned beat on the rising edge of the
// selected (possibly inverted) system clock, detects new beats through the
// strobe-side toggle and presents BURST_LEN beats with a valid flag.
// Assumes one beat per system clock period while a burst is active.
module ddr_rd_resync
    import ddr_rd_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BURST_LEN = 4
) (
    input  logic              sys_clk,
    input  logic              rst_n,
    input  rs_pol_e           pol,
    input  logic              start,
    input  logic [DATA_W-1:0] rise_al,
    input  logic [DATA_W-1:0] fall_al,
    input  logic              beat_tog,
    output logic [DATA_W-1:0] rise_word,
    output logic [DATA_W-1:0] fall_word,
    output logic              word_valid,
    output logic              busy
);
    localparam int CNT_W = $clog2(BURST_LEN + 1);

    logic              rs_clk;
    logic [DATA_W-1:0] rise_s;
    logic [DATA_W-1:0] fall_s;
    logic              tog_s;
    logic              tog_p;
    logic              beat;
    logic [CNT_W-1:0]  left_q;

    assign rs_clk = sys_clk ^ logic'(pol);

    // Resample the aligned beat on the selected system edge.
    always_ff @(posedge rs_clk) begin
        if (!rst_n) begin
            rise_s <= '0;
            fall_s <= '0;
            tog_s  <= 1'b0;
        end else begin
            rise_s <= rise_al;
            fall_s <= fall_al;
            tog_s  <= beat_tog;
        end
    end

    // Remember the last toggle seen on the system side.
    always_ff @(posedge sys_clk) begin
        if (!rst_n) tog_p <= 1'b0;
        else        tog_p <= tog_s;
    end

    assign beat = tog_s ^ tog_p;
    assign busy = (left_q != '0);

    // Count the burst down and present each new beat for one cycle.
    always_ff @(posedge sys_clk) begin
        if (!rst_n) begin
            left_q     <= '0;
            word_valid <= 1'b0;
            rise_word  <= '0;
            fall_word  <= '0;
        end else if (start) begin
            left_q     <= CNT_W'(BURST_LEN);
            word_valid <= 1'b0;
        end else if (beat && busy) begin
            left_q     <= left_q - CNT_W'(1);
            word_valid <= 1'b1;
            rise_word  <= rise_s;
            fall_word  <= fall_s;
        end else begin
            word_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/ddr_rd_capture.sv
`timescale 1ns/1ps
// DDR read capture top: strobe-domain capture, automatic resync polarity
// and delivery of BURST_LEN beats into the system clock domain.
// Assumes dqs runs at the sys_clk frequency and is centred on dq.
module ddr_rd_capture
    import ddr_rd_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BURST_LEN = 4
) (
    input  logic              sys_clk,
    input  logic              rst_n,
    input  logic              dqs,
    input  logic [DATA_W-1:0] dq,
    input  logic              prmb_det,
    output logic [DATA_W-1:0] rise_word,
    output logic [DATA_W-1:0] fall_word,
    output logic              word_valid,
    output logic              clk_pol
);
    logic [DATA_W-1:0] rise_al;
    logic [DATA_W-1:0] fall_al;
    logic              beat_tog;
    logic              busy;
    logic              start;
    rs_pol_e           pol;

    ddr_dqs_capture #(.DATA_W(DATA_W)) u_cap (
        .dqs      (dqs),
        .rst_n    (rst_n),
        .dq       (dq),
        .rise_al  (rise_al),
        .fall_al  (fall_al),
        .beat_tog (beat_tog)
    );

    ddr_pol_detect u_pol (
        .sys_clk  (sys_clk),
        .rst_n    (rst_n),
        .prmb_det (prmb_det),
        .busy     (busy),
        .pol      (pol),
        .start    (start)
    );

    ddr_rd_resync #(.DATA_W(DATA_W), .BURST_LEN(BURST_LEN)) u_rs (
        .sys_clk    (sys_clk),
        .rst_n      (rst_n),
        .pol        (pol),
        .start      (start),
        .rise_al    (rise_al),
        .fall_al    (fall_al),
        .beat_tog   (beat_tog),
        .rise_word  (rise_word),
        .fall_word  (fall_word),
        .word_valid (word_valid),
        .busy       (busy)
    );

    assign clk_pol = logic'(pol);
endmodule

// File: rtl/ddr_rd_capture_chk.sv
`timescale 1ns/1ps
// Port-level checker for ddr_rd_capture, attached by bind.
module ddr_rd_capture_chk #(
    parameter int DATA_W    = 8,
    parameter int BURST_LEN = 4
) (
    input logic              sys_clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] rise_word,
    input logic [DATA_W-1:0] fall_word,
    input logic              word_valid,
    input logic              clk_pol
);
    localparam int RUN_W = $clog2(BURST_LEN + 2) + 1;

    logic [RUN_W-1:0] run_q;

    // Length of the current run of valid cycles.
    always_ff @(posedge sys_clk) begin
        if (!rst_n)          run_q <= '0;
        else if (word_valid) run_q <= run_q + RUN_W'(1);
        else                 run_q <= '0;
    end

    // R7
    valid_run_max_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        word_valid |-> (run_q < RUN_W'(BURST_LEN)));

    // R7
    valid_run_len_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (!word_valid && run_q != '0) |-> (run_q == RUN_W'(BURST_LEN)));

    // R6
    pol_hold_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        word_valid |-> $stable(clk_pol));

    // R9
    reset_clear_chk: assert property (@(posedge sys_clk)
        !rst_n |=> (!word_valid && !clk_pol && rise_word == '0 && fall_word == '0));

    // R1
    data_known_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
        word_valid |-> !$isunknown({rise_word, fall_word}));
endmodule

bind ddr_rd_capture ddr_rd_capture_chk #(.DATA_W(DATA_W), .BURST_LEN(BURST_LEN)) u_chk (
    .sys_clk    (sys_clk),
    .rst_n      (rst_n),
    .rise_word  (rise_word),
    .fall_word  (fall_word),
    .word_valid (word_valid),
    .clk_pol    (clk_pol)
);

// File: tb/ddr_rd_capture_tb.sv
`timescale 1ns/1ps
module ddr_rd_capture_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 8;
    localparam int BL         = 4;

    logic          sys_clk = 1'b0;
    logic          rst_n   = 1'b0;
    logic          dqs     = 1'b0;
    logic [DW-1:0] dq      = '0;
    logic          prmb    = 1'b0;
    logic [DW-1:0] rise_word;
    logic [DW-1:0] fall_word;
    logic          word_valid;
    logic          clk_pol;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Monitor state
    int            nv;
    int            runs;
    int            first_t;
    int            pol_seen;
    bit            prev_v = 1'b0;
    logic [DW-1:0] got_r [16];
    logic [DW-1:0] got_f [16];

    ddr_rd_capture #(.DATA_W(DW), .BURST_LEN(BL)) u_dut (
        .sys_clk    (sys_clk),
        .rst_n      (rst_n),
        .dqs        (dqs),
        .dq         (dq),
        .prmb_det   (prmb),
        .rise_word  (rise_word),
        .fall_word  (fall_word),
        .word_valid (word_valid),
        .clk_pol    (clk_pol)
    );

    always #(CLK_PERIOD / 2) sys_clk = ~sys_clk;

    // Collect delivered beats away from the rising edge.
    always @(negedge sys_clk) begin
        if (word_valid) begin
            if (nv == 0) begin
                first_t  = int'($time);
                pol_seen = int'(clk_pol);
            end
            if (nv < 16) begin
                got_r[nv] = rise_word;
                got_f[nv] = fall_word;
            end
            if (!prev_v) runs++;
            nv++;
        end
        prev_v = word_valid;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int next_edge(input int t, input int res);
        int x = t + 1;
        while (x % CLK_PERIOD != res) x++;
        return x;
    endfunction

    function automatic int pick_phase();
        int p = 1 + int'($urandom % 8);
        if (p >= 5) p++;
        return p;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        prmb  = 1'b0;
        repeat (3) begin
            #2.5 dqs = 1'b1;
            #2.5 dqs = 1'b0;
        end
        repeat (2) @(posedge sys_clk);
        @(negedge sys_clk);
        // R9: cleared outputs while reset is held
        chk(word_valid == 1'b0, "R9 valid", int'(word_valid), 0);
        chk(clk_pol == 1'b0, "R9 pol", int'(clk_pol), 0);
        chk(rise_word == '0 && fall_word == '0, "R9 words",
            int'({rise_word, fall_word}), 0);
        rst_n = 1'b1;
    endtask

    // One read burst with the strobe at 'phi' ns after a system rising edge.
    task automatic run_burst(input int phi, input int mode, input bit use_pre,
                             input bit glitch, input string tag);
        logic [DW-1:0] pw [BL];
        logic [DW-1:0] nw [BL];
        int t0, tp, r0, epol, eobs;
        for (int k = 0; k < BL; k++) begin
            case (mode)
                1:       begin pw[k] = 8'h55; nw[k] = 8'hAA; end
                2:       begin pw[k] = 8'hFF; nw[k] = 8'h00; end
                3:       begin pw[k] = DW'(1 << k); nw[k] = ~DW'(1 << k); end
                default: begin pw[k] = DW'($urandom); nw[k] = DW'($urandom); end
            endcase
        end
        @(posedge sys_clk);
        t0 = int'($time);
        nv = 0; runs = 0; first_t = -1; pol_seen = -1;
        #(10 + phi);
        tp = t0 + 10 + phi;
        if (use_pre) prmb = 1'b1;
        #7.5;
        for (int k = 0; k < BL; k++) begin
            dq = pw[k];
            #2.5 dqs = 1'b1;
            #2.5 dq = nw[k];
            if (glitch && k == 1) prmb = 1'b0;
            if (glitch && k == 2) prmb = 1'b1;
            #2.5 dqs = 1'b0;
            #2.5;
        end
        dq = DW'($urandom);
        #30 prmb = 1'b0;
        repeat (6) @(posedge sys_clk);
        @(negedge sys_clk);

        if (!use_pre) begin
            // R8: no preamble, no delivery
            chk(nv == 0, {"R8 no valid ", tag}, nv, 0);
            return;
        end
        r0   = tp + 10;
        epol = ((tp % CLK_PERIOD) > CLK_PERIOD / 2) ? 1 : 0;
        eobs = next_edge(next_edge(r0 + 10, epol ? 0 : 5), 5) + 5;
        // R4 / R10: polarity from clock level at the preamble edge
        chk(pol_seen == epol, {"R4 R10 pol ", tag}, pol_seen, epol);
        // R6: polarity unchanged by the mid-burst preamble edge
        if (glitch) chk(int'(clk_pol) == epol, {"R6 pol hold ", tag}, int'(clk_pol), epol);
        // R7: exactly BL beats
        chk(nv == BL, {"R7 count ", tag}, nv, BL);
        // R3: one contiguous run
        chk(runs == 1, {"R3 contiguous ", tag}, runs, 1);
        // R5: first beat timing
        chk(first_t == eobs, {"R5 first beat time ", tag}, first_t, eobs);
        for (int k = 0; k < BL && k < nv; k++) begin
            // R1 / R3: rising word of beat k, in order
            chk(got_r[k] == pw[k], {"R1 rise ", tag}, int'(got_r[k]), int'(pw[k]));
            // R2: falling word paired with the same beat
            chk(got_f[k] == nw[k], {"R2 fall ", tag}, int'(got_f[k]), int'(nw[k]));
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        nv = 0; runs = 0; first_t = -1; pol_seen = -1;
        do_reset();
        // Directed: both polarities and phases close to the edges
        run_burst(3, 1, 1'b1, 1'b0, "phi3");
        run_burst(7, 2, 1'b1, 1'b0, "phi7 R10");
        run_burst(1, 3, 1'b1, 1'b0, "phi1");
        run_burst(9, 0, 1'b1, 1'b0, "phi9");
        run_burst(6, 0, 1'b1, 1'b0, "phi6");
        run_burst(4, 0, 1'b1, 1'b0, "phi4");
        // R8: strobe without preamble
        run_burst(2, 0, 1'b0, 1'b0, "nopre");
        // R6: a second preamble edge at the opposite clock level mid-burst
        run_burst(3, 0, 1'b1, 1'b1, "glitch");
        // Random phases and data
        for (int i = 0; i < 10; i++) run_burst(pick_phase(), 0, 1'b1, 1'b0, "rand");
        // Leave polarity high, then reset must clear it (R9)
        run_burst(2, 0, 1'b1, 1'b0, "pre-reset");
        do_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge sys_clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule